// File: doc/BRIEF.md
# Paired Complex Multiply-Accumulate Engine

This block holds two matched arithmetic slices that together work on complex numbers: one slice keeps and processes real parts, the other imaginary parts. Each slice owns a 256-word local RAM, an X operand (the registered RAM read), a Y operand register, a multiplier, an adder and a 40-bit accumulator. A complex value lives at one address, with its real part in the real slice's RAM and its imaginary part in the imaginary slice's RAM. Every cycle both RAMs are read at the address given by an external pointer unit, so a cross path lets either slice load its Y from the opposite RAM, optionally negated.

A shared instruction stream (opcode, source select, slice mask, address) drives both slices. A complex product (a+jb)(c+jd) takes five issue slots: load both Y from their own RAM, multiply with real X, load the negated imaginary word into the real Y, load the real word into the imaginary Y, and multiply-accumulate with imaginary X. Two idle slots later a store writes each accumulator, saturated to 16 bits, back to its own RAM. Operands can also be written in through a data-load opcode and read out through registered read ports.

Top module: `cmac_pair`

## Requirements
- R1: While reset is high and in the cycle after it, both read outputs are 0, and a store issued first after reset writes 0 to both RAMs.
- R2: Opcode 5 (load) writes `wr_re_i`/`wr_im_i` into the real/imaginary RAM at `addr_i`; each cycle the RAMs are read at `addr_i` and the words appear on `rd_re_o`/`rd_im_o` after the next clock edge.
- R3: Opcode 1 (Y load) updates only the slices whose `mask_i` bit is set (bit 0 real, bit 1 imaginary); an unmasked slice keeps its Y.
- R4: On a Y load, `msel_i[0]`=1 takes the word from the other slice's RAM and `msel_i[1]`=1 negates it; the most negative word -32768 loads as +32768.
- R5: Opcode 2 (multiply) overwrites each accumulator with X*Y, where both slices take X from the same RAM: real if `msel_i[0]`=0, imaginary if 1.
- R6: Opcode 3 (multiply-accumulate) adds X*Y, X chosen as in R5, to each accumulator.
- R7: A store (opcode 4) issued three or more cycles after a multiply or multiply-accumulate stores its result; a store issued two cycles after stores the earlier accumulator value.
- R8: A store writes each accumulator into its own RAM at `addr_i`, saturated to the signed 16-bit range 0x8000..0x7FFF.
- R9: The five-step sequence yields Re = a*c - b*d and Im = a*d + b*c, saturated, for any 16-bit operands including -32768.
- R10: Opcode 0 (idle) changes neither RAM nor either accumulator, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Opcode: 0 idle, 1 Y load, 2 multiply, 3 multiply-accumulate, 4 store, 5 data load |
| msel_i | input | 2 | Bit 0: cross/imaginary source select; bit 1: negate on Y load |
| mask_i | input | 2 | Y load slice enables: bit 0 real, bit 1 imaginary |
| addr_i | input | 8 | RAM address from the pointer unit |
| wr_re_i | input | 16 | Real word for data load |
| wr_im_i | input | 16 | Imaginary word for data load |
| rd_re_o | output | 16 | Registered read of the real RAM |
| rd_im_o | output | 16 | Registered read of the imaginary RAM |

## Verification
The hardest state to reach is an accumulator beyond the 16-bit range in a slice whose Y was just negated from -32768, since it needs a cross or negated load, a masked load that leaves the other slice alone, and a multiply from a chosen RAM lined up in consecutive slots. The bench builds this with directed instruction sequences after a table of complex operand pairs, and it also issues a store exactly two cycles after a multiply to capture the stale accumulator value at the pipeline boundary.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_LDY = 3'd1,
    OP_MPY = 3'd2,
    OP_MAC = 3'd3,
    OP_STA = 3'd4,
    OP_WR  = 3'd5
  } cmac_op_e;
endpackage

// File: rtl/cmac_ram.sv
module cmac_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // read-first registered output
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[addr];
  end
endmodule

// File: rtl/cmac_slice.sv
module cmac_slice #(
  parameter int DW   = 16,
  parameter int ACCW = 40
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_y,
  input  logic            y_neg,
  input  logic [DW-1:0]   y_src,
  input  logic            mul_en,
  input  logic            mac_mode,
  input  logic [DW-1:0]   x_val,
  output logic [DW:0]     y_o,
  output logic [ACCW-1:0] acc_o,
  output logic [DW-1:0]   st_data
);
  localparam int YW = DW + 1;
  localparam int PW = YW + DW;
  localparam logic signed [ACCW-1:0] MAXV = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACCW-1:0] MINV = {{(ACCW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [YW-1:0]   y_q;
  logic signed [YW-1:0]   y_ext;
  logic signed [PW-1:0]   x_w, y_w, prod_q;
  logic                   p_vld, p_mac;
  logic signed [ACCW-1:0] acc_q, prod_ext;

  assign y_ext    = {y_src[DW-1], y_src};
  assign x_w      = {{(PW-DW){x_val[DW-1]}}, x_val};
  assign y_w      = {{(PW-YW){y_q[YW-1]}}, y_q};
  assign prod_ext = {{(ACCW-PW){prod_q[PW-1]}}, prod_q};

  always_ff @(posedge clk) begin
    if (rst)       y_q <= '0;
    else if (ld_y) y_q <= y_neg ? -y_ext : y_ext;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      p_vld  <= 1'b0;
      p_mac  <= 1'b0;
    end else begin
      p_vld <= mul_en;
      p_mac <= mac_mode;
      if (mul_en) prod_q <= x_w * y_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        acc_q <= '0;
    else if (p_vld) acc_q <= p_mac ? acc_q + prod_ext : prod_ext;
  end

  always_comb begin
    if (acc_q > MAXV)      st_data = MAXV[DW-1:0];
    else if (acc_q < MINV) st_data = MINV[DW-1:0];
    else                   st_data = acc_q[DW-1:0];
  end

  assign y_o   = y_q;
  assign acc_o = acc_q;
endmodule

// File: rtl/cmac_pair.sv
module cmac_pair #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int ACCW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_i,
  input  logic [1:0]    msel_i,
  input  logic [1:0]    mask_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_re_i,
  input  logic [DW-1:0] wr_im_i,
  output logic [DW-1:0] rd_re_o,
  output logic [DW-1:0] rd_im_o
);
  import cmac_pkg::*;
  localparam int NSL = 2;

  logic [DW-1:0]   rdq    [NSL];
  logic [DW-1:0]   wr_in  [NSL];
  logic [DW-1:0]   wdata  [NSL];
  logic [DW-1:0]   st_d   [NSL];
  logic [DW:0]     y_q    [NSL];
  logic [ACCW-1:0] acc_q  [NSL];
  logic            we;

  // stage-1 control, aligned with the registered RAM read
  logic [2:0] s1_op;
  logic       s1_sel, s1_neg;
  logic [1:0] s1_mask;

  // names exposed for the bound checker
  logic [DW:0]     y_re_w, y_im_w;
  logic [ACCW-1:0] acc_re_w, acc_im_w;
  logic [DW-1:0]   wdata_re_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_op   <= OP_NOP;
      s1_sel  <= 1'b0;
      s1_neg  <= 1'b0;
      s1_mask <= '0;
    end else begin
      s1_op   <= op_i;
      s1_sel  <= msel_i[0];
      s1_neg  <= msel_i[1];
      s1_mask <= mask_i;
    end
  end

  assign we       = (op_i == OP_STA) || (op_i == OP_WR);
  assign wr_in[0] = wr_re_i;
  assign wr_in[1] = wr_im_i;

  for (genvar k = 0; k < NSL; k++) begin : g_slice
    assign wdata[k] = (op_i == OP_STA) ? st_d[k] : wr_in[k];

    cmac_ram #(.DW(DW), .AW(AW)) ram_i (
      .clk   (clk),
      .rst   (rst),
      .we    (we),
      .addr  (addr_i),
      .wdata (wdata[k]),
      .rdata (rdq[k])
    );

    cmac_slice #(.DW(DW), .ACCW(ACCW)) slice_i (
      .clk      (clk),
      .rst      (rst),
      .ld_y     ((s1_op == OP_LDY) && s1_mask[k]),
      .y_neg    (s1_neg),
      .y_src    (s1_sel ? rdq[NSL-1-k] : rdq[k]),
      .mul_en   ((s1_op == OP_MPY) || (s1_op == OP_MAC)),
      .mac_mode (s1_op == OP_MAC),
      .x_val    (s1_sel ? rdq[1] : rdq[0]),
      .y_o      (y_q[k]),
      .acc_o    (acc_q[k]),
      .st_data  (st_d[k])
    );
  end

  assign rd_re_o    = rdq[0];
  assign rd_im_o    = rdq[1];
  assign y_re_w     = y_q[0];
  assign y_im_w     = y_q[1];
  assign acc_re_w   = acc_q[0];
  assign acc_im_w   = acc_q[1];
  assign wdata_re_w = wdata[0];
endmodule

// File: rtl/cmac_pair_chk.sv
module cmac_pair_chk #(
  parameter int DW   = 16,
  parameter int AW   = 8,
  parameter int ACCW = 40
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      op_i,
  input logic [1:0]      msel_i,
  input logic [1:0]      mask_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wr_re_i,
  input logic [DW-1:0]   rd_re_o,
  input logic [DW-1:0]   rd_im_o,
  input logic [DW:0]     y_re_w,
  input logic [DW:0]     y_im_w,
  input logic [ACCW-1:0] acc_re_w,
  input logic [ACCW-1:0] acc_im_w,
  input logic [DW-1:0]   wdata_re_w
);
  import cmac_pkg::*;
  localparam logic signed [ACCW-1:0] TOPV = {{(ACCW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [DW-1:0]          SATP = {1'b0, {(DW-1){1'b1}}};

  logic [DW:0] rd_re_x;
  assign rd_re_x = {rd_re_o[DW-1], rd_re_o};

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_re_o == '0 && rd_im_o == '0));

  // R2
  load_read_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_WR) ##1 (op_i == OP_NOP && addr_i == $past(addr_i))
    |=> (rd_re_o == $past(wr_re_i, 2)));

  // R3
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LDY && !mask_i[0]) |=> ##1 $stable(y_re_w));

  // R4
  neg_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_LDY && mask_i[0] && msel_i == 2'b10)
    |=> ##1 (y_re_w == -$past(rd_re_x)));

  // R10
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(op_i == OP_MPY || op_i == OP_MAC) |=> ##2 ($stable(acc_re_w) && $stable(acc_im_w)));

  // R8
  sat_high_chk: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_STA && $signed(acc_re_w) > TOPV) |-> (wdata_re_w == SATP));
endmodule

bind cmac_pair cmac_pair_chk #(.DW(DW), .AW(AW), .ACCW(ACCW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .msel_i     (msel_i),
  .mask_i     (mask_i),
  .addr_i     (addr_i),
  .wr_re_i    (wr_re_i),
  .rd_re_o    (rd_re_o),
  .rd_im_o    (rd_im_o),
  .y_re_w     (y_re_w),
  .y_im_w     (y_im_w),
  .acc_re_w   (acc_re_w),
  .acc_im_w   (acc_im_w),
  .wdata_re_w (wdata_re_w)
);

// File: tb/cmac_pair_tb_top.sv
`timescale 1ns/1ps
module cmac_pair_tb_top;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NV = 8;

  // each entry {a, b, c, d} for (a + jb) * (c + jd)
  localparam logic [63:0] VEC [NV] = '{
    {16'h0003, 16'h0004, 16'h0005, 16'h0006},
    {16'hFFFE, 16'h0007, 16'h000B, 16'hFFFB},
    {16'h0064, 16'hFF9C, 16'h0064, 16'h0064},
    {16'h8000, 16'h0000, 16'h0001, 16'h0000},
    {16'h8000, 16'h8000, 16'h8000, 16'h8000},
    {16'h7FFF, 16'h7FFF, 16'h7FFF, 16'h8001},
    {16'h04D2, 16'hFFB3, 16'h0019, 16'hFFF6},
    {16'hFFFF, 16'h0001, 16'hFFFF, 16'hFFFF}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_i = 3'd0;
  logic [1:0]    msel_i = 2'b00;
  logic [1:0]    mask_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wr_re_i = '0;
  logic [DW-1:0] wr_im_i = '0;
  logic [DW-1:0] rd_re_o, rd_im_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  cmac_pair dut_i (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .msel_i  (msel_i),
    .mask_i  (mask_i),
    .addr_i  (addr_i),
    .wr_re_i (wr_re_i),
    .wr_im_i (wr_im_i),
    .rd_re_o (rd_re_o),
    .rd_im_o (rd_im_o)
  );

  function automatic logic [15:0] sat16(longint v);
    if (v > 32767)       return 16'h7FFF;
    else if (v < -32768) return 16'h8000;
    else                 return v[15:0];
  endfunction

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [1:0] ms, logic [1:0] mk,
                       logic [AW-1:0] ad, logic [DW-1:0] wre, logic [DW-1:0] wim);
    @(negedge clk);
    op_i = op; msel_i = ms; mask_i = mk; addr_i = ad; wr_re_i = wre; wr_im_i = wim;
  endtask

  task automatic rd_check(logic [AW-1:0] ad, logic [15:0] ere, logic [15:0] eim, string tag);
    issue(3'd0, 2'b00, 2'b00, ad, '0, '0);
    @(negedge clk);
    chk({tag, " re"}, rd_re_o, ere);
    chk({tag, " im"}, rd_im_o, eim);
  endtask

  task automatic idle2();
    issue(3'd0, 2'b00, 2'b00, '0, '0, '0);
    issue(3'd0, 2'b00, 2'b00, '0, '0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs zero in reset, store right after reset writes zero
    repeat (3) @(negedge clk);
    chk("R1 rd_re in reset", rd_re_o, 16'h0000);
    chk("R1 rd_im in reset", rd_im_o, 16'h0000);
    rst = 1'b0;
    issue(3'd4, 2'b00, 2'b00, 8'd5, '0, '0);
    rd_check(8'd5, 16'h0000, 16'h0000, "R1 store after reset");

    // R2: load then read back
    issue(3'd5, 2'b00, 2'b00, 8'd20, 16'h1234, 16'hABCD);
    rd_check(8'd20, 16'h1234, 16'hABCD, "R2 load/read");

    // R9: table of complex products
    for (int i = 0; i < NV; i++) begin
      logic [15:0] a, b, c, d;
      longint re, im;
      {a, b, c, d} = VEC[i];
      re = longint'($signed(a)) * longint'($signed(c)) - longint'($signed(b)) * longint'($signed(d));
      im = longint'($signed(a)) * longint'($signed(d)) + longint'($signed(b)) * longint'($signed(c));
      issue(3'd5, 2'b00, 2'b00, 8'd1, a, b);
      issue(3'd5, 2'b00, 2'b00, 8'd2, c, d);
      issue(3'd1, 2'b00, 2'b11, 8'd2, '0, '0);
      issue(3'd2, 2'b00, 2'b00, 8'd1, '0, '0);
      issue(3'd1, 2'b11, 2'b01, 8'd2, '0, '0);
      issue(3'd1, 2'b01, 2'b10, 8'd2, '0, '0);
      issue(3'd3, 2'b01, 2'b00, 8'd1, '0, '0);
      idle2();
      issue(3'd4, 2'b00, 2'b00, 8'd3, '0, '0);
      rd_check(8'd3, sat16(re), sat16(im), $sformatf("R9 vec%0d", i));
    end
    // last vector leaves accumulators at (2, 0)

    // R10: idle with live data changes nothing
    issue(3'd0, 2'b10, 2'b11, 8'd3, 16'h5555, 16'hAAAA);
    issue(3'd0, 2'b01, 2'b11, 8'd3, 16'h5555, 16'hAAAA);
    idle2();
    rd_check(8'd3, 16'h0002, 16'h0000, "R10 ram unchanged");
    issue(3'd4, 2'b00, 2'b00, 8'd4, '0, '0);
    rd_check(8'd4, 16'h0002, 16'h0000, "R10 acc unchanged");

    // R7 and R5: stale vs ready store around a multiply from real X
    issue(3'd5, 2'b00, 2'b00, 8'd8, 16'd3, 16'd5);
    issue(3'd1, 2'b00, 2'b11, 8'd8, '0, '0);
    issue(3'd2, 2'b00, 2'b00, 8'd8, '0, '0);
    issue(3'd0, 2'b00, 2'b00, 8'd0, '0, '0);
    issue(3'd4, 2'b00, 2'b00, 8'd6, '0, '0);
    issue(3'd4, 2'b00, 2'b00, 8'd7, '0, '0);
    rd_check(8'd6, 16'h0002, 16'h0000, "R7 early store stale");
    rd_check(8'd7, 16'd9, 16'd15, "R7 R5 store after result");

    // R5: both slices take X from imaginary RAM
    issue(3'd2, 2'b01, 2'b00, 8'd8, '0, '0);
    idle2();
    issue(3'd4, 2'b00, 2'b00, 8'd11, '0, '0);
    rd_check(8'd11, 16'd15, 16'd25, "R5 imag X");

    // R4, R3, R8: negate -32768 into real Y only, then saturate
    issue(3'd5, 2'b00, 2'b00, 8'd9, 16'h8000, 16'h0001);
    issue(3'd1, 2'b10, 2'b01, 8'd9, '0, '0);
    issue(3'd2, 2'b01, 2'b00, 8'd9, '0, '0);
    idle2();
    issue(3'd4, 2'b00, 2'b00, 8'd10, '0, '0);
    rd_check(8'd10, 16'h7FFF, 16'd5, "R4 R3 R8 neg min");

    // R6: accumulate on top
    issue(3'd3, 2'b01, 2'b00, 8'd9, '0, '0);
    idle2();
    issue(3'd4, 2'b00, 2'b00, 8'd12, '0, '0);
    rd_check(8'd12, 16'h7FFF, 16'd10, "R6 accumulate");

    // R8: negative saturation in the imaginary slice
    issue(3'd1, 2'b00, 2'b01, 8'd9, '0, '0);
    issue(3'd2, 2'b00, 2'b00, 8'd9, '0, '0);
    idle2();
    issue(3'd4, 2'b00, 2'b00, 8'd13, '0, '0);
    rd_check(8'd13, 16'h7FFF, 16'h8000, "R8 both rails");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule